// File: doc/BRIEF.md
# Audio Codec Mixer and Control Register Bank

This block is the register file that a host uses to configure an audio codec: output and input volume levels, record routing, powerdown controls, variable sample rates and a paged window for extension registers. The host reaches it through a 16-bit word-addressed port with a 7-bit byte address, a write data bus, a write strobe and a combinational read data bus.

Each register has its own write rule, fixed at build time by feature parameters. Registers of features that are absent ignore writes and read as zero. Level fields that do not support 6-bit attenuation saturate to the 5-bit maximum. The sample-rate registers are forced back to the 48 kHz default whenever the host turns off variable-rate mode. A write to address zero restores every register to its power-on value.

Top module: `codec_regbank`

## Requirements
- R1: Address bit 0 is ignored: byte addresses 2n and 2n+1 reach the same 16-bit register for both reads and writes.
- R2: A write to address 0x00 restores every register, including the extension pages and the page select, to its reset value and discards the write data. Address 0x00 reads the build-time capability word (default 0x0140).
- R3: The master level register (0x02) keeps the bits under mask 0xBF3F. Without 6-bit support, a left field with bit 13 set is stored as bits 13:8 = 0x1F and a right field with bit 5 set as bits 5:0 = 0x1F.
- R4: Writes to aux-out (0x04), mono-out (0x06), phone (0x0C), video (0x14) and aux-in (0x16) have no effect when that feature is absent, and the register reads 0. The default build lacks video only. Mono-out uses mask 0x803F with right-field saturation, and phone uses mask 0x801F.
- R5: Line-in (0x10), CD (0x12) and PCM-out (0x18) use mask 0x9F1F, mic (0x0E) uses 0x805F, record select (0x1A) 0x0707 and record gain (0x1C) 0x8F0F.
- R6: In the powerdown register (0x26) only the bits of the 8-bit powerdown mask (default 0x3F), placed at bits 15:8, are writable. All other bits keep their value.
- R7: The DAC rate registers (0x2C, 0x2E, 0x30) accept writes only when the variable-rate DAC capability exists, and the ADC rate registers (0x32, 0x34) only when the variable-rate ADC capability exists. A value above the maximum rate (48000) is stored as the maximum.
- R8: A write to extended control (0x2A) with bit 0 clear sets all DAC rate registers to 48000. A write with bit 3 clear sets all ADC rate registers to 48000. Only bits 0 and 3 are writable, each when its capability exists.
- R9: After reset: master 0x8000, aux-out and mono-out 0x8000, phone and mic 0x8008, line-in, CD, aux-in and PCM-out 0x8808, powerdown 0x000F, every rate 48000 (0xBB80), extended control 0.
- R10: The read-only capability register (0x28) holds the codec number in bits 15:14, the revision in bits 11:10, the ADC variable-rate capability in bit 3 and the DAC variable-rate capability in bit 0 (default 0x4809).
- R11: Bits 3:0 of register 0x24 select the page seen through 0x60-0x6E, and 0x24 is writable only for revision 2 or later. Each of the pages below the page count (default 2) holds eight writable words. A page number at or above the count reads zero and ignores writes.
- R12: Registers 0x7C and 0x7E are read-only and hold the upper and lower halves of the 32-bit vendor code (default 0x5A4B4C21).
- R13: Read data is a combinational function of the address, and unimplemented addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 7 | Byte address, bit 0 ignored |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |

## Verification
Every register drives the read mux directly, so a wrong stored value appears on rdata_o in the same cycle the host addresses that register. The stimulus therefore follows each write with reads of both the target and any neighbour it could disturb. A missed rate snap-back or a lost powerdown bit shows at the first read after the control write. A page-select fault shows as data from the wrong page, or as data where zero is expected at an out-of-range page. A soft-reset fault is caught by reading back registers from every submodule after one write to address zero.

// File: rtl/codec_regbank_pkg.sv
`timescale 1ns/1ps
package codec_regbank_pkg;
  typedef logic [5:0] waddr_t;

  localparam int unsigned NUM_MIX       = 12;
  localparam int unsigned NUM_RATES     = 5;
  localparam int unsigned NUM_DAC_RATES = 3;
  localparam logic [15:0] RATE_DEFAULT  = 16'd48000;

  localparam waddr_t W_RESET   = 6'h00;
  localparam waddr_t W_PAGESEL = 6'h12;
  localparam waddr_t W_PWR     = 6'h13;
  localparam waddr_t W_EXTID   = 6'h14;
  localparam waddr_t W_EXTCTL  = 6'h15;
  localparam waddr_t W_RATE0   = 6'h16;
  localparam waddr_t W_VEND_HI = 6'h3E;
  localparam waddr_t W_VEND_LO = 6'h3F;
  localparam logic [2:0] WIN_TAG = 3'b110;  // word 0x30..0x37

  localparam int unsigned EXT_DAC_VR_BIT = 0;
  localparam int unsigned EXT_ADC_VR_BIT = 3;

  // mixer slot order: 0 master,1 aux-out,2 mono,3 phone,4 mic,5 line,
  // 6 cd,7 video,8 aux-in,9 pcm,10 rec select,11 rec gain
  function automatic waddr_t mix_addr(int idx);
    case (idx)
      0: return 6'h01;
      1: return 6'h02;
      2: return 6'h03;
      3: return 6'h06;
      4: return 6'h07;
      5: return 6'h08;
      6: return 6'h09;
      7: return 6'h0A;
      8: return 6'h0B;
      9: return 6'h0C;
      10: return 6'h0D;
      default: return 6'h0E;
    endcase
  endfunction

  function automatic logic [15:0] mix_mask(int idx);
    case (idx)
      0, 1: return 16'hBF3F;
      2: return 16'h803F;
      3: return 16'h801F;
      4: return 16'h805F;
      10: return 16'h0707;
      11: return 16'h8F0F;
      default: return 16'h9F1F;
    endcase
  endfunction

  function automatic logic [15:0] mix_default(int idx);
    case (idx)
      0, 1, 2: return 16'h8000;
      3, 4: return 16'h8008;
      10, 11: return 16'h0000;
      default: return 16'h8808;
    endcase
  endfunction

  // bit1: left field saturates, bit0: right field saturates
  function automatic logic [1:0] mix_sides(int idx);
    case (idx)
      0, 1: return 2'b11;
      2: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [15:0] clamp_level(logic [15:0] v, logic [1:0] sides);
    logic [15:0] r;
    r = v;
    if (sides[1] && r[13]) begin
      r[13]   = 1'b0;
      r[12:8] = 5'h1F;
    end
    if (sides[0] && r[5]) begin
      r[5]   = 1'b0;
      r[4:0] = 5'h1F;
    end
    return r;
  endfunction
endpackage

// File: rtl/codec_mixer_regs.sv
`timescale 1ns/1ps
module codec_mixer_regs
  import codec_regbank_pkg::*;
#(
  parameter logic [NUM_MIX-1:0] PRESENT = '1,
  parameter logic [NUM_MIX-1:0] WIDE    = '0,
  parameter logic [7:0]         PD_MASK = 8'h3F
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         soft_rst_i,
  input  logic                         we_i,
  input  waddr_t                       waddr_i,
  input  logic [15:0]                  wdata_i,
  output logic [NUM_MIX-1:0][15:0]     mix_q_o,
  output logic [15:0]                  pwr_q_o
);
  localparam logic [15:0] PWR_WMASK = {PD_MASK, 8'h00};
  localparam logic [15:0] PWR_RESET = 16'h000F;

  for (genvar g = 0; g < NUM_MIX; g++) begin : g_mix
    if (PRESENT[g]) begin : g_on
      localparam logic [15:0] DEF   = mix_default(g);
      localparam logic [15:0] MASK  = mix_mask(g);
      localparam logic [1:0]  SIDES = WIDE[g] ? 2'b00 : mix_sides(g);
      localparam waddr_t      ADDR  = mix_addr(g);
      logic [15:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        q <= DEF;
        else if (soft_rst_i)                q <= DEF;
        else if (we_i && waddr_i == ADDR)   q <= clamp_level(wdata_i & MASK, SIDES);
      end
      assign mix_q_o[g] = q;
    end else begin : g_off
      assign mix_q_o[g] = 16'h0000;
    end
  end

  logic [15:0] pwr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pwr_q <= PWR_RESET;
    else if (soft_rst_i)                  pwr_q <= PWR_RESET;
    else if (we_i && waddr_i == W_PWR)    pwr_q <= (wdata_i & PWR_WMASK) | (pwr_q & ~PWR_WMASK);
  end
  assign pwr_q_o = pwr_q;
endmodule

// File: rtl/codec_rate_ctl.sv
`timescale 1ns/1ps
module codec_rate_ctl
  import codec_regbank_pkg::*;
#(
  parameter bit HAS_DAC_VR = 1'b1,
  parameter bit HAS_ADC_VR = 1'b1,
  parameter int unsigned MAX_RATE = 48000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        soft_rst_i,
  input  logic                        we_i,
  input  waddr_t                      waddr_i,
  input  logic [15:0]                 wdata_i,
  output logic [15:0]                 ext_q_o,
  output logic [NUM_RATES-1:0][15:0]  rate_q_o
);
  localparam logic [15:0] MAX_W = 16'(MAX_RATE);
  localparam logic [15:0] EXT_WMASK =
    (16'(HAS_DAC_VR) << EXT_DAC_VR_BIT) | (16'(HAS_ADC_VR) << EXT_ADC_VR_BIT);

  logic        ext_wr;
  logic [15:0] ext_new;
  logic [15:0] ext_q;
  logic [15:0] rate_wval;

  assign ext_wr    = we_i && (waddr_i == W_EXTCTL);
  assign ext_new   = wdata_i & EXT_WMASK;
  assign rate_wval = (wdata_i > MAX_W) ? MAX_W : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ext_q <= '0;
    else if (soft_rst_i) ext_q <= '0;
    else if (ext_wr)     ext_q <= ext_new;
  end
  assign ext_q_o = ext_q;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam bit          IS_DAC = (g < NUM_DAC_RATES);
    localparam bit          CAP    = IS_DAC ? HAS_DAC_VR : HAS_ADC_VR;
    localparam int unsigned EN_BIT = IS_DAC ? EXT_DAC_VR_BIT : EXT_ADC_VR_BIT;
    localparam waddr_t      ADDR   = W_RATE0 + waddr_t'(g);
    logic [15:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= RATE_DEFAULT;
      else if (soft_rst_i)                           q <= RATE_DEFAULT;
      else if (ext_wr && !ext_new[EN_BIT])           q <= RATE_DEFAULT;
      else if (CAP && we_i && waddr_i == ADDR)       q <= rate_wval;
    end
    assign rate_q_o[g] = q;
  end
endmodule

// File: rtl/codec_page_bank.sv
`timescale 1ns/1ps
module codec_page_bank
  import codec_regbank_pkg::*;
#(
  parameter int unsigned PAGE_COUNT   = 2,
  parameter int unsigned PAGE_WORDS   = 8,
  parameter bit          SEL_WRITABLE = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        soft_rst_i,
  input  logic        we_i,
  input  waddr_t      waddr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] sel_q_o,
  output logic [15:0] win_rdata_o
);
  localparam int unsigned PIDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;
  localparam int unsigned SLOT_W = $clog2(PAGE_WORDS);
  localparam logic [4:0]  PCNT   = 5'(PAGE_COUNT);

  logic [3:0]              sel_q;
  logic                    sel_ok;
  logic                    in_win;
  logic [PIDX_W-1:0]       pidx;
  logic [SLOT_W-1:0]       slot;
  logic [15:0]             mem [PAGE_COUNT][PAGE_WORDS];

  assign sel_ok = {1'b0, sel_q} < PCNT;
  assign in_win = (waddr_i[5:3] == WIN_TAG);
  assign pidx   = sel_q[PIDX_W-1:0];
  assign slot   = waddr_i[SLOT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           sel_q <= '0;
    else if (soft_rst_i)                                   sel_q <= '0;
    else if (SEL_WRITABLE && we_i && waddr_i == W_PAGESEL) sel_q <= wdata_i[3:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || soft_rst_i) begin
      for (int p = 0; p < PAGE_COUNT; p++)
        for (int w = 0; w < PAGE_WORDS; w++) mem[p][w] <= '0;
    end else if (we_i && in_win && sel_ok) begin
      mem[pidx][slot] <= wdata_i;
    end
  end

  assign sel_q_o     = {12'h000, sel_q};
  assign win_rdata_o = sel_ok ? mem[pidx][slot] : 16'h0000;
endmodule

// File: rtl/codec_regbank.sv
`timescale 1ns/1ps
module codec_regbank
  import codec_regbank_pkg::*;
#(
  parameter bit          HAS_MASTER_6B = 1'b0,
  parameter bit          HAS_AUXOUT    = 1'b1,
  parameter bit          HAS_AUXOUT_6B = 1'b0,
  parameter bit          HAS_MONOOUT   = 1'b1,
  parameter bit          HAS_MONO_6B   = 1'b0,
  parameter bit          HAS_PHONE     = 1'b1,
  parameter bit          HAS_VIDEO     = 1'b0,
  parameter bit          HAS_AUXIN     = 1'b1,
  parameter bit          HAS_DAC_VR    = 1'b1,
  parameter bit          HAS_ADC_VR    = 1'b1,
  parameter logic [7:0]  PD_MASK       = 8'h3F,
  parameter logic [1:0]  CODEC_NUM     = 2'd1,
  parameter logic [1:0]  REVISION      = 2'd2,
  parameter logic [15:0] RESET_CAPS    = 16'h0140,
  parameter logic [31:0] VENDOR_CODE   = 32'h5A4B_4C21,
  parameter int unsigned MAX_RATE      = 48000,
  parameter int unsigned PAGE_COUNT    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [6:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o
);
  localparam logic [NUM_MIX-1:0] MIX_PRESENT = {
    1'b1, 1'b1, 1'b1, HAS_AUXIN, HAS_VIDEO, 1'b1,
    1'b1, 1'b1, HAS_PHONE, HAS_MONOOUT, HAS_AUXOUT, 1'b1};
  localparam logic [NUM_MIX-1:0] MIX_WIDE = {
    {(NUM_MIX-3){1'b0}}, HAS_MONO_6B, HAS_AUXOUT_6B, HAS_MASTER_6B};
  localparam logic [15:0] EXTID = {CODEC_NUM, 2'b00, REVISION, 6'b000000,
                                   HAS_ADC_VR, 2'b00, HAS_DAC_VR};

  waddr_t                      waddr;
  logic                        soft_rst;
  logic                        unused_addr_lsb;
  logic [NUM_MIX-1:0][15:0]    mix_q;
  logic [15:0]                 pwr_q;
  logic [15:0]                 ext_q;
  logic [NUM_RATES-1:0][15:0]  rate_q;
  logic [15:0]                 page_sel;
  logic [15:0]                 win_rdata;

  assign waddr           = addr_i[6:1];
  assign unused_addr_lsb = addr_i[0];
  assign soft_rst        = we_i && (waddr == W_RESET);

  codec_mixer_regs #(
    .PRESENT (MIX_PRESENT),
    .WIDE    (MIX_WIDE),
    .PD_MASK (PD_MASK)
  ) u_mixer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .we_i       (we_i),
    .waddr_i    (waddr),
    .wdata_i    (wdata_i),
    .mix_q_o    (mix_q),
    .pwr_q_o    (pwr_q)
  );

  codec_rate_ctl #(
    .HAS_DAC_VR (HAS_DAC_VR),
    .HAS_ADC_VR (HAS_ADC_VR),
    .MAX_RATE   (MAX_RATE)
  ) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .we_i       (we_i),
    .waddr_i    (waddr),
    .wdata_i    (wdata_i),
    .ext_q_o    (ext_q),
    .rate_q_o   (rate_q)
  );

  codec_page_bank #(
    .PAGE_COUNT   (PAGE_COUNT),
    .PAGE_WORDS   (8),
    .SEL_WRITABLE (REVISION >= 2'd2)
  ) u_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst),
    .we_i        (we_i),
    .waddr_i     (waddr),
    .wdata_i     (wdata_i),
    .sel_q_o     (page_sel),
    .win_rdata_o (win_rdata)
  );

  always_comb begin
    rdata_o = 16'h0000;
    for (int i = 0; i < NUM_MIX; i++)
      if (waddr == mix_addr(i)) rdata_o = mix_q[i];
    for (int i = 0; i < NUM_RATES; i++)
      if (waddr == W_RATE0 + waddr_t'(i)) rdata_o = rate_q[i];
    if (waddr[5:3] == WIN_TAG) rdata_o = win_rdata;
    case (waddr)
      W_RESET:   rdata_o = RESET_CAPS;
      W_PAGESEL: rdata_o = page_sel;
      W_PWR:     rdata_o = pwr_q;
      W_EXTID:   rdata_o = EXTID;
      W_EXTCTL:  rdata_o = ext_q;
      W_VEND_HI: rdata_o = VENDOR_CODE[31:16];
      W_VEND_LO: rdata_o = VENDOR_CODE[15:0];
      default:   ;
    endcase
  end
endmodule

// File: rtl/codec_regbank_chk.sv
`timescale 1ns/1ps
module codec_regbank_chk
  import codec_regbank_pkg::*;
#(
  parameter logic [7:0]  PD_MASK       = 8'h3F,
  parameter bit          HAS_MASTER_6B = 1'b0,
  parameter logic [31:0] VENDOR_CODE   = 32'h0,
  parameter int unsigned MAX_RATE      = 48000
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       we_i,
  input logic [6:0]                 addr_i,
  input logic [15:0]                wdata_i,
  input logic [15:0]                rdata_o,
  input logic [NUM_MIX-1:0][15:0]   mix_q,
  input logic [15:0]                pwr_q,
  input logic [NUM_RATES-1:0][15:0] rate_q
);
  localparam logic [15:0] PWR_WMASK = {PD_MASK, 8'h00};
  localparam logic [15:0] MAX_W     = 16'(MAX_RATE);

  assert_soft_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[6:1] == W_RESET) |=> (pwr_q == 16'h000F && mix_q[0] == 16'h8000));

  if (!HAS_MASTER_6B) begin : g_clamp
    assert_master_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mix_q[0][13] || mix_q[0][5]));
  end

  assert_pwr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[6:1] == W_PWR) |=> ((pwr_q & ~PWR_WMASK) == ($past(pwr_q) & ~PWR_WMASK)));

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_cap
    assert_rate_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rate_q[g] <= MAX_W);
  end

  assert_dac_snap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[6:1] == W_EXTCTL && !wdata_i[EXT_DAC_VR_BIT]) |=>
      (rate_q[0] == RATE_DEFAULT && rate_q[1] == RATE_DEFAULT && rate_q[2] == RATE_DEFAULT));

  assert_vendor_ro_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[6:1] == W_VEND_HI) |-> (rdata_o == VENDOR_CODE[31:16]));
endmodule

bind codec_regbank codec_regbank_chk #(
  .PD_MASK       (PD_MASK),
  .HAS_MASTER_6B (HAS_MASTER_6B),
  .VENDOR_CODE   (VENDOR_CODE),
  .MAX_RATE      (MAX_RATE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .mix_q   (mix_q),
  .pwr_q   (pwr_q),
  .rate_q  (rate_q)
);

// File: tb/tb_codec_regbank.sv
`timescale 1ns/1ps
module tb_codec_regbank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [6:0]  addr;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  codec_regbank dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic expect_rd(input logic [6:0] a, input logic [15:0] e, input string req);
    item_t it;
    @(negedge clk);
    addr_i = a; we_i = 1'b0;
    it.addr = a; it.exp = e; it.req = req;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  // monitor: compare one cycle after the driver settles the address
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_run++;
        if (rdata_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, rdata_o, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // reset state (R9, R10, R12, R2, R4)
    expect_rd(7'h00, 16'h0140, "R2 caps");
    expect_rd(7'h02, 16'h8000, "R9 master");
    expect_rd(7'h04, 16'h8000, "R9 auxout");
    expect_rd(7'h0C, 16'h8008, "R9 phone");
    expect_rd(7'h0E, 16'h8008, "R9 mic");
    expect_rd(7'h10, 16'h8808, "R9 line");
    expect_rd(7'h18, 16'h8808, "R9 pcm");
    expect_rd(7'h26, 16'h000F, "R9 pwr");
    expect_rd(7'h2C, 16'hBB80, "R9 dac rate");
    expect_rd(7'h34, 16'hBB80, "R9 adc rate");
    expect_rd(7'h28, 16'h4809, "R10 extid");
    expect_rd(7'h7C, 16'h5A4B, "R12 vendor hi");
    expect_rd(7'h7E, 16'h4C21, "R12 vendor lo");
    expect_rd(7'h14, 16'h0000, "R4 video absent");

    // R3 master mask and saturation
    wr(7'h02, 16'hFFFF);
    expect_rd(7'h02, 16'h9F1F, "R3 saturate");
    wr(7'h02, 16'h1A15);
    expect_rd(7'h02, 16'h1A15, "R3 in range");

    // R1 odd byte address
    wr(7'h03, 16'h0005);
    expect_rd(7'h02, 16'h0005, "R1 odd write");
    expect_rd(7'h03, 16'h0005, "R1 odd read");

    // R4 feature gating and mono/phone masks
    wr(7'h14, 16'h1234);
    expect_rd(7'h14, 16'h0000, "R4 video ignored");
    wr(7'h06, 16'hFFFF);
    expect_rd(7'h06, 16'h801F, "R4 mono");
    wr(7'h0C, 16'hFFFF);
    expect_rd(7'h0C, 16'h801F, "R4 phone");

    // R5 masks
    wr(7'h10, 16'hFFFF);
    expect_rd(7'h10, 16'h9F1F, "R5 line");
    wr(7'h0E, 16'hFFFF);
    expect_rd(7'h0E, 16'h805F, "R5 mic");
    wr(7'h1A, 16'hFFFF);
    expect_rd(7'h1A, 16'h0707, "R5 recsel");
    wr(7'h1C, 16'hFFFF);
    expect_rd(7'h1C, 16'h8F0F, "R5 recgain");

    // R6 powerdown
    wr(7'h26, 16'hFFF0);
    expect_rd(7'h26, 16'h3F0F, "R6 set");
    wr(7'h26, 16'h0000);
    expect_rd(7'h26, 16'h000F, "R6 clear");

    // R7 rates
    wr(7'h2A, 16'hFFFF);
    expect_rd(7'h2A, 16'h0009, "R8 ext mask");
    wr(7'h2C, 16'h5622);
    expect_rd(7'h2C, 16'h5622, "R7 dac rate");
    wr(7'h32, 16'hFFFF);
    expect_rd(7'h32, 16'hBB80, "R7 clamp");
    wr(7'h34, 16'h1F40);
    expect_rd(7'h34, 16'h1F40, "R7 adc rate");

    // R8 snap-back
    wr(7'h2A, 16'h0008);
    expect_rd(7'h2C, 16'hBB80, "R8 dac snap");
    expect_rd(7'h34, 16'h1F40, "R8 adc kept");
    wr(7'h2A, 16'h0000);
    expect_rd(7'h34, 16'hBB80, "R8 adc snap");

    // R10 / R12 read-only
    wr(7'h28, 16'h0000);
    expect_rd(7'h28, 16'h4809, "R10 read only");
    wr(7'h7C, 16'h0000);
    expect_rd(7'h7C, 16'h5A4B, "R12 read only");

    // R11 paging
    wr(7'h24, 16'h0001);
    expect_rd(7'h24, 16'h0001, "R11 select");
    wr(7'h60, 16'hABCD);
    expect_rd(7'h60, 16'hABCD, "R11 page1 word");
    expect_rd(7'h62, 16'h0000, "R11 page1 other");
    wr(7'h24, 16'h0000);
    expect_rd(7'h60, 16'h0000, "R11 page0 clean");
    wr(7'h60, 16'h1111);
    expect_rd(7'h60, 16'h1111, "R11 page0 word");
    wr(7'h24, 16'h0005);
    wr(7'h60, 16'h2222);
    expect_rd(7'h60, 16'h0000, "R11 out of range");
    wr(7'h24, 16'h0001);
    expect_rd(7'h60, 16'hABCD, "R11 page1 kept");
    wr(7'h24, 16'hFFF3);
    expect_rd(7'h24, 16'h0003, "R11 sel mask");
    wr(7'h24, 16'h0000);

    // R13 unimplemented
    expect_rd(7'h40, 16'h0000, "R13 hole");
    expect_rd(7'h08, 16'h0000, "R13 tone");

    // R2 soft reset
    wr(7'h00, 16'h1234);
    expect_rd(7'h00, 16'h0140, "R2 caps kept");
    expect_rd(7'h02, 16'h8000, "R2 master");
    expect_rd(7'h10, 16'h8808, "R2 line");
    expect_rd(7'h26, 16'h000F, "R2 pwr");
    expect_rd(7'h2A, 16'h0000, "R2 ext");
    expect_rd(7'h24, 16'h0000, "R2 page sel");
    expect_rd(7'h60, 16'h0000, "R2 page data");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule